// File: doc/BRIEF.md
# Barrel Shifter with Carry and Condition Flags

This block performs a single 32-bit shift in one of four ways (logical left, logical right, arithmetic right, rotate right) and produces the carry that the shift generates together with negative and zero flags for the result. It also reports how many cycles the operation costs. The shift amount comes either from a 5-bit field held in the instruction or from the low byte of a general register value. Each amount source has its own rules for a zero amount, and the rules for amounts at and beyond the operand width differ by shift type.

A request is accepted when `req_valid` and `req_ready` are both high. The shifted value, flags and cost appear on the response outputs one clock later with `rsp_valid` high. Each response lasts for one cycle. Fetching the operand, writing the result back and decoding the instruction are left to the surrounding pipeline.

Top module: `shf_flag_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, `req_ready` and `rsp_valid` are both low. From then on `req_ready` stays high.
- R2: An accepted request gives `rsp_valid` high on the next cycle. A cycle with no accepted request gives `rsp_valid` low on the next cycle.
- R3: When the amount comes from the register value, only bits 7:0 of that value are used. Bits above 7 do not affect any response field.
- R4: A register amount of zero returns the operand unchanged and the incoming carry unchanged, for every shift type.
- R5: Logical left shift (kind code 0). For amounts 1 to 31, carry is the last bit shifted out. For exactly 32, the result is zero and carry is operand bit 0. Above 32, the result and the carry are both zero.
- R6: Logical right shift (kind code 1). For amounts 1 to 31, carry is operand bit (amount-1). For exactly 32, the result is zero and carry is operand bit 31. Above 32, the result and the carry are both zero. An immediate amount of zero is treated as 32.
- R7: Arithmetic right shift (kind code 2). For amounts 1 to 31, carry is operand bit (amount-1). For 32 or more, every result bit equals operand bit 31, and so does the carry. An immediate amount of zero is treated as 32.
- R8: Rotate right (kind code 3) with a nonzero amount. The operand is rotated by the amount's low 5 bits, and carry becomes the bit that ends up in result bit 31. When those low 5 bits are zero, the result is the operand and carry is operand bit 31.
- R9: An immediate amount of zero for logical left shift or rotate right returns the operand and the incoming carry unchanged.
- R10: `rsp_neg` is bit 31 of the result, `rsp_zero` is high exactly when the result is zero, and `rsp_ovf` repeats `ovf_in` from the request.
- R11: `rsp_cycles` is 1 for an immediate amount and 2 for a register amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_operand | input | 32 | Value to shift |
| req_kind | input | 2 | 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right |
| req_by_reg | input | 1 | 1: amount from `req_reg_amt`; 0: amount from `req_imm` |
| req_imm | input | 5 | Immediate shift amount |
| req_reg_amt | input | 32 | Register value holding the amount in bits 7:0 |
| carry_in | input | 1 | Current carry flag |
| ovf_in | input | 1 | Current overflow flag |
| rsp_valid | output | 1 | Response fields are valid |
| rsp_result | output | 32 | Shifted value |
| rsp_carry | output | 1 | New carry flag |
| rsp_neg | output | 1 | New negative flag |
| rsp_zero | output | 1 | New zero flag |
| rsp_ovf | output | 1 | Overflow flag passed through |
| rsp_cycles | output | 2 | Cycle cost of the operation |

## Verification
The hardest cases to reach are register amounts of exactly 32, amounts above 32, and rotate amounts that are nonzero but multiples of 32. Uniform random register values almost never produce these, because the upper register bits are random and the low byte is rarely one of those values. The stimulus therefore draws the low byte from a small set of boundary values (0, 1, 31, 32, 33, 64, 255), fills the upper 24 bits with random junk, and runs directed passes over every shift type for both amount sources. A bit-serial reference function, which shifts one position per loop step, gives the expected result and carry, so every boundary rule follows from the step count rather than being written out case by case.

// File: rtl/shf_pkg.sv
package shf_pkg;
   typedef enum logic [1:0] {
      SH_LSL = 2'd0,
      SH_LSR = 2'd1,
      SH_ASR = 2'd2,
      SH_ROR = 2'd3
   } shf_kind_e;
endpackage

// File: rtl/shf_amount.sv
// Turns the selected amount source into one effective shift count.
module shf_amount
   import shf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8,
   parameter int IMM_W  = 5
) (
   input  shf_kind_e          kind,
   input  logic               by_reg,
   input  logic [IMM_W-1:0]   imm,
   input  logic [DATA_W-1:0]  reg_val,
   output logic [AMT_W-1:0]   amt
);
   localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

   always_comb begin
      if (by_reg) begin
         amt = reg_val[AMT_W-1:0];
      end else if ((imm == '0) && ((kind == SH_LSR) || (kind == SH_ASR))) begin
         amt = FULL;
      end else begin
         amt = {{(AMT_W-IMM_W){1'b0}}, imm};
      end
   end
endmodule

// File: rtl/shf_core.sv
// Combinational shifter: one lane per shift type, then a selection by kind.
module shf_core
   import shf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8
) (
   input  logic [DATA_W-1:0] x,
   input  shf_kind_e         kind,
   input  logic [AMT_W-1:0]  amt,
   input  logic              carry_in,
   output logic [DATA_W-1:0] res,
   output logic              carry_out
);
   localparam int ROT_W = $clog2(DATA_W);
   localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);
   localparam int N_KIND = 4;

   logic [N_KIND-1:0][DATA_W-1:0] lane_res;
   logic [N_KIND-1:0]             lane_c;
   logic                          amt_zero;

   assign amt_zero = (amt == '0);

   for (genvar k = 0; k < N_KIND; k++) begin : g_lane
      if (k == int'(SH_LSL)) begin : g_lsl
         logic [DATA_W:0] w;
         assign w           = {1'b0, x} << amt;
         assign lane_res[k] = w[DATA_W-1:0];
         assign lane_c[k]   = amt_zero ? carry_in : w[DATA_W];
      end else if (k == int'(SH_LSR)) begin : g_lsr
         logic [DATA_W:0] w;
         assign w           = {x, 1'b0} >> amt;
         assign lane_res[k] = w[DATA_W:1];
         assign lane_c[k]   = amt_zero ? carry_in : w[0];
      end else if (k == int'(SH_ASR)) begin : g_asr
         logic signed [DATA_W:0] sw;
         logic        [DATA_W:0] w;
         logic        [AMT_W-1:0] clamp;
         assign clamp       = (amt > FULL) ? FULL : amt;
         assign sw          = {x, 1'b0};
         assign w           = sw >>> clamp;
         assign lane_res[k] = w[DATA_W:1];
         assign lane_c[k]   = amt_zero ? carry_in : w[0];
      end else begin : g_ror
         logic [2*DATA_W-1:0] dbl;
         logic [ROT_W-1:0]    rot;
         assign rot         = amt[ROT_W-1:0];
         assign dbl         = {x, x} >> rot;
         assign lane_res[k] = dbl[DATA_W-1:0];
         assign lane_c[k]   = amt_zero ? carry_in : dbl[DATA_W-1];
      end
   end

   assign res       = lane_res[kind];
   assign carry_out = lane_c[kind];
endmodule

// File: rtl/shf_flag_unit.sv
// Registered shift unit: amount selection, shift, flags and cycle cost.
module shf_flag_unit
   import shf_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int IMM_W    = $clog2(DATA_W),
   parameter int AMT_W    = 8,
   parameter int COST_W   = 2,
   parameter int IMM_COST = 1,
   parameter int REG_COST = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [DATA_W-1:0] req_operand,
   input  logic [1:0]        req_kind,
   input  logic              req_by_reg,
   input  logic [IMM_W-1:0]  req_imm,
   input  logic [DATA_W-1:0] req_reg_amt,
   input  logic              carry_in,
   input  logic              ovf_in,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_result,
   output logic              rsp_carry,
   output logic              rsp_neg,
   output logic              rsp_zero,
   output logic              rsp_ovf,
   output logic [COST_W-1:0] rsp_cycles
);
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_chk_w
      $error("DATA_W must be a power of two of at least 8");
   end
   if (DATA_W >= (1 << AMT_W) || AMT_W > DATA_W) begin : g_chk_amt
      $error("AMT_W must hold DATA_W and fit in the operand");
   end
   if (IMM_W != $clog2(DATA_W)) begin : g_chk_imm
      $error("IMM_W must equal clog2(DATA_W)");
   end
   if (REG_COST >= (1 << COST_W) || IMM_COST >= (1 << COST_W)) begin : g_chk_cost
      $error("COST_W too narrow for the costs");
   end

   localparam logic [COST_W-1:0] C_IMM = COST_W'(IMM_COST);
   localparam logic [COST_W-1:0] C_REG = COST_W'(REG_COST);

   shf_kind_e         kind;
   logic [AMT_W-1:0]  amt;
   logic [DATA_W-1:0] sh_res;
   logic              sh_c;
   logic              ready_q;
   logic              fire;

   assign kind      = shf_kind_e'(req_kind);
   assign req_ready = ready_q;
   assign fire      = req_valid && ready_q;

   shf_amount #(.DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_W(IMM_W)) u_amt (
      .kind    (kind),
      .by_reg  (req_by_reg),
      .imm     (req_imm),
      .reg_val (req_reg_amt),
      .amt     (amt)
   );

   shf_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
      .x         (req_operand),
      .kind      (kind),
      .amt       (amt),
      .carry_in  (carry_in),
      .res       (sh_res),
      .carry_out (sh_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q    <= 1'b0;
         rsp_valid  <= 1'b0;
         rsp_result <= '0;
         rsp_carry  <= 1'b0;
         rsp_neg    <= 1'b0;
         rsp_zero   <= 1'b0;
         rsp_ovf    <= 1'b0;
         rsp_cycles <= '0;
      end else begin
         ready_q   <= 1'b1;
         rsp_valid <= fire;
         if (fire) begin
            rsp_result <= sh_res;
            rsp_carry  <= sh_c;
            rsp_neg    <= sh_res[DATA_W-1];
            rsp_zero   <= (sh_res == '0);
            rsp_ovf    <= ovf_in;
            rsp_cycles <= req_by_reg ? C_REG : C_IMM;
         end
      end
   end

   // R2: one response per accepted request, none otherwise
   a_r2_rsp_follows_fire: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> rsp_valid);
   a_r2_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> !rsp_valid);
   // R4: register amount of zero keeps operand and carry
   a_r4_zero_reg_amount: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && req_by_reg && req_reg_amt[AMT_W-1:0] == '0) |=>
      (rsp_result == $past(req_operand) && rsp_carry == $past(carry_in)));
   // R7: arithmetic shift by width or more fills with sign
   a_r7_asr_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && kind == SH_ASR && req_by_reg && req_reg_amt[AMT_W-1:0] >= AMT_W'(DATA_W)) |=>
      (rsp_result == {DATA_W{$past(req_operand[DATA_W-1])}} && rsp_carry == $past(req_operand[DATA_W-1])));
   // R10: overflow flag passes through
   a_r10_ovf_pass: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> rsp_ovf == $past(ovf_in));
   // R11: cost follows the amount source
   a_r11_cost: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> rsp_cycles == ($past(req_by_reg) ? C_REG : C_IMM));
endmodule

// File: tb/tb_shf_flag_unit.sv
`timescale 1ns/1ps
module tb_shf_flag_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_operand = '0;
   logic [1:0]  req_kind = '0;
   logic        req_by_reg = 1'b0;
   logic [4:0]  req_imm = '0;
   logic [31:0] req_reg_amt = '0;
   logic        carry_in = 1'b0;
   logic        ovf_in = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_result;
   logic        rsp_carry, rsp_neg, rsp_zero, rsp_ovf;
   logic [1:0]  rsp_cycles;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   shf_flag_unit dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_operand(req_operand), .req_kind(req_kind), .req_by_reg(req_by_reg),
      .req_imm(req_imm), .req_reg_amt(req_reg_amt), .carry_in(carry_in),
      .ovf_in(ovf_in), .rsp_valid(rsp_valid), .rsp_result(rsp_result),
      .rsp_carry(rsp_carry), .rsp_neg(rsp_neg), .rsp_zero(rsp_zero),
      .rsp_ovf(rsp_ovf), .rsp_cycles(rsp_cycles)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Bit-serial model: one position per step, carry is the bit leaving.
   function automatic logic [32:0] model(input logic [31:0] x, input logic [1:0] kind,
                                         input logic by_reg, input logic [4:0] imm,
                                         input logic [31:0] regv, input logic cin);
      int a;
      logic [31:0] r = x;
      logic        c = cin;
      if (by_reg) a = int'(regv[7:0]);
      else if (imm == 0 && (kind == 2'd1 || kind == 2'd2)) a = 32;
      else a = int'(imm);
      for (int i = 0; i < a; i++) begin
         case (kind)
            2'd0: begin c = r[31]; r = {r[30:0], 1'b0}; end
            2'd1: begin c = r[0];  r = {1'b0, r[31:1]}; end
            2'd2: begin c = r[0];  r = {r[31], r[31:1]}; end
            default: begin c = r[0]; r = {r[0], r[31:1]}; end
         endcase
      end
      return {c, r};
   endfunction

   function automatic string tag_for(input logic [1:0] kind, input logic by_reg,
                                     input logic [4:0] imm, input logic [31:0] regv);
      if (by_reg && regv[7:0] == 0) return "R4";
      if (!by_reg && imm == 0 && (kind == 2'd0 || kind == 2'd3)) return "R9";
      case (kind)
         2'd0: return "R5";
         2'd1: return "R6";
         2'd2: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic apply(input logic [31:0] x, input logic [1:0] kind, input logic by_reg,
                        input logic [4:0] imm, input logic [31:0] regv, input logic cin,
                        input logic vin, input string force_tag);
      logic [32:0] e;
      string tg;
      e  = model(x, kind, by_reg, imm, regv, cin);
      tg = (force_tag == "") ? tag_for(kind, by_reg, imm, regv) : force_tag;
      @(negedge clk);
      req_valid = 1'b1; req_operand = x; req_kind = kind; req_by_reg = by_reg;
      req_imm = imm; req_reg_amt = regv; carry_in = cin; ovf_in = vin;
      @(negedge clk);
      req_valid = 1'b0;
      check("R2", 64'(rsp_valid), 64'(1'b1));
      check(tg, 64'({rsp_carry, rsp_result}), 64'(e));
      check("R10", 64'({rsp_neg, rsp_zero, rsp_ovf}), 64'({e[31], e[31:0] == 0, vin}));
      check("R11", 64'(rsp_cycles), by_reg ? 64'd2 : 64'd1);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int amts[6] = '{0, 1, 31, 32, 33, 255};
      int lows[7] = '{0, 1, 31, 32, 33, 64, 255};
      logic [31:0] pats[4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F69, 32'h0000_0000};
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      check("R1", 64'({req_ready, rsp_valid}), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 64'({req_ready, rsp_valid}), 64'b10);

      // register amounts across boundaries, all types
      for (int k = 0; k < 4; k++)
         for (int a = 0; a < 6; a++)
            for (int p = 0; p < 4; p++) begin
               apply(pats[p], 2'(k), 1'b1, 5'd0, 32'(amts[a]), 1'b1, 1'b0, "");
               apply(pats[p], 2'(k), 1'b1, 5'd0, 32'(amts[a]), 1'b0, 1'b1, "");
            end
      // immediate amounts incl. zero, all types
      for (int k = 0; k < 4; k++)
         for (int p = 0; p < 4; p++) begin
            apply(pats[p], 2'(k), 1'b0, 5'd0,  '0, 1'b1, 1'b0, "");
            apply(pats[p], 2'(k), 1'b0, 5'd1,  '0, 1'b0, 1'b0, "");
            apply(pats[p], 2'(k), 1'b0, 5'd31, '0, 1'b1, 1'b1, "");
         end
      // R3: upper register bits must not matter
      apply(32'hDEAD_BEEF, 2'd0, 1'b1, 5'd0, 32'hFFFF_FF00, 1'b1, 1'b0, "R3");
      apply(32'hDEAD_BEEF, 2'd1, 1'b1, 5'd0, 32'h1234_5604, 1'b0, 1'b0, "R3");
      apply(32'hDEAD_BEEF, 2'd3, 1'b1, 5'd0, 32'h0000_0120, 1'b0, 1'b0, "R3");
      // R2: idle cycle drops valid
      @(negedge clk);
      check("R2", 64'(rsp_valid), 64'd0);
      // random mix with boundary-biased low bytes
      for (int n = 0; n < 600; n++) begin
         logic [31:0] rv;
         rv = $urandom;
         if ($urandom % 2) rv[7:0] = 8'(lows[$urandom % 7]);
         apply($urandom, 2'($urandom), 1'($urandom), 5'($urandom), rv,
               1'($urandom), 1'($urandom), "");
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule